// File: doc/BRIEF.md
# Prescaled Watch Timer

This block is a single timer channel made of a 16-bit prescaler and a 16-bit down counter. Both are loaded from one 32-bit count register: the upper half sets the clock divisor, the lower half sets how many divided ticks make one period. A 32-bit mode register starts and stops the channel and selects one-shot, continuous or watchdog behaviour. In timer use, every completed period raises a one-cycle expiry pulse. A one-shot run stops itself after its first period. A continuous run reloads and keeps going.

In watchdog use, the channel runs until software services it. Servicing is a write of a fixed key byte into the top byte of the mode register, and each such write restarts the period. If a period completes without service, the block raises a one-cycle reset request and sets a flag that stays set until reset. While the watchdog runs, the channel is locked: mode writes that would turn it into a plain timer or stop it are refused, and a refusal pulse reports this. The only way out is a write that clears the watchdog and enable bits together, and that write is honoured only when the design is built with the no-way-out parameter at 0.

Top module: `prescaled_watch_timer`

## Requirements
- R1: After reset, expTick, rstReq, wdFired, refused, running and wdLocked are all 0.
- R2: With count-register bits 31:16 = P and bits 15:0 = C (both nonzero), an accepted mode write with bit 12 set loads the channel. The first expiry pulse is visible P×C clock cycles after the clock edge that captures the write.
- R3: A prescale field of 0 divides by 65536, and a period field of 0 counts 65536 prescaled ticks.
- R4: Mode bit 12 enables counting, bit 10 selects continuous operation and bit 15 selects watchdog operation. An accepted write with bit 12 clear stops the channel: running goes to 0 and no further expiry occurs.
- R5: With bit 10 clear and bit 15 clear, the channel gives exactly one expTick pulse and then running drops to 0.
- R6: With bit 10 set and bit 15 clear, expTick repeats every P×C cycles.
- R7: A mode write with bits 15 and 12 set locks the channel (wdLocked = 1) and forces continuous mode off. Each unserviced period gives a one-cycle rstReq pulse and no expTick. After each such expiry the watchdog reloads and keeps counting. wdFired sets on the first such expiry and stays set until reset.
- R8: While locked, a kick write with key byte 0xA5 (the value written to mode bits 31:24) restarts the full P×C period from the capturing edge.
- R9: A kick write with any other byte value leaves the watchdog timing unchanged.
- R10: While locked, a mode write that does not set both bit 15 and bit 12, and that is not the unlock write of R11, is refused. refused pulses for one cycle after the capturing edge, and the lock and the watchdog timing are unchanged.
- R11: With NO_WAY_OUT = 0, a mode write with bits 15 and 12 both clear unlocks and stops the channel. With NO_WAY_OUT = 1, the lock is never released except by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Write wrData into the mode register |
| countWr | input | 1 | Write wrData into the count register |
| kickWr | input | 1 | Byte write of kickByte into mode bits 31:24 |
| wrData | input | 32 | Write data for the mode and count registers |
| kickByte | input | 8 | Byte value for a kick write |
| expTick | output | 1 | One-cycle timer expiry pulse |
| rstReq | output | 1 | One-cycle watchdog reset request |
| wdFired | output | 1 | Sticky watchdog-expired flag |
| refused | output | 1 | One-cycle pulse when a locked channel rejects a mode write |
| running | output | 1 | Channel is counting |
| wdLocked | output | 1 | Watchdog lock is active |

## Verification
The bench builds the block with its default parameters: 16-bit prescale and period fields, key byte 0xA5 and NO_WAY_OUT = 0. Full 16-bit fields let it reach the zero-means-65536 cases for both the prescaler and the period counter, each taking 65536 cycles. The zero no-way-out setting lets it walk the full watchdog path: lock, service, ignored bad key, refusal, expiry with sticky flag, and then unlock. Small P and C values elsewhere make the one-shot, continuous and stop timings exact to the cycle.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int BUS_W    = 32;
  localparam int EN_BIT   = 12;
  localparam int CONT_BIT = 10;
  localparam int WD_BIT   = 15;

  typedef struct packed {
    logic load;  // reload prescaler and period counter
    logic run;   // counting allowed this cycle
  } dp_strobe_t;
endpackage

// File: rtl/pwt_count_path.sv
module pwt_count_path
  import pwt_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strb,
  input  logic [PRE_W-1:0] preVal,
  input  logic [CNT_W-1:0] perVal,
  output logic             expire
);
  logic [PRE_W-1:0] psQ;
  logic [CNT_W-1:0] cntQ;
  logic             psTick;

  // A load value of 0 wraps through all ones, giving 2**W steps.
  assign psTick = strb.run && (psQ == PRE_W'(1));
  assign expire = psTick && (cntQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psQ  <= '0;
      cntQ <= '0;
    end else if (strb.load) begin
      psQ  <= preVal;
      cntQ <= perVal;
    end else if (strb.run) begin
      psQ <= psTick ? preVal : psQ - PRE_W'(1);
      if (psTick) begin
        cntQ <= (cntQ == CNT_W'(1)) ? perVal : cntQ - CNT_W'(1);
      end
    end
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (psQ == $past(preVal)) && (cntQ == $past(perVal)));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !strb.load) |=> (cntQ == $past(perVal)));
endmodule

// File: rtl/pwt_mode_ctrl.sv
module pwt_mode_ctrl
  import pwt_pkg::*;
#(
  parameter int         PRE_W      = 16,
  parameter int         CNT_W      = 16,
  parameter logic [7:0] KICK_VAL   = 8'hA5,
  parameter bit         NO_WAY_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic              countWr,
  input  logic              kickWr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [7:0]        kickByte,
  input  logic              expire,
  output dp_strobe_t        strb,
  output logic [PRE_W-1:0]  preVal,
  output logic [CNT_W-1:0]  perVal,
  output logic              expTick,
  output logic              rstReq,
  output logic              wdFired,
  output logic              refused,
  output logic              running,
  output logic              wdLocked
);
  localparam int CFG_W = PRE_W + CNT_W;

  logic [CFG_W-1:0] countQ;
  logic enQ, contQ, wdQ;
  logic wantEn, wantCont, wantWd;
  logic lockedNow, restartWr, unlockWr, acceptWr, refuseWr, kickOk;

  assign preVal = countQ[CNT_W +: PRE_W];
  assign perVal = countQ[CNT_W-1:0];

  assign wantEn   = wrData[EN_BIT];
  assign wantCont = wrData[CONT_BIT];
  assign wantWd   = wrData[WD_BIT];

  always_comb begin
    lockedNow = wdQ && enQ;
    restartWr = modeWr && wantWd && wantEn;
    unlockWr  = modeWr && !wantWd && !wantEn && (NO_WAY_OUT == 1'b0);
    acceptWr  = modeWr && (!lockedNow || restartWr || unlockWr);
    refuseWr  = modeWr && !acceptWr;
    kickOk    = kickWr && lockedNow && (kickByte == KICK_VAL);
    strb.load = (acceptWr && wantEn) || kickOk;
    strb.run  = enQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      enQ     <= 1'b0;
      contQ   <= 1'b0;
      wdQ     <= 1'b0;
      expTick <= 1'b0;
      rstReq  <= 1'b0;
      wdFired <= 1'b0;
      refused <= 1'b0;
    end else begin
      if (countWr) countQ <= wrData[CFG_W-1:0];
      if (acceptWr) begin
        enQ   <= wantEn;
        wdQ   <= wantWd;
        contQ <= wantCont && !wantWd;
      end else if (expire && !contQ && !wdQ) begin
        enQ <= 1'b0;
      end
      expTick <= expire && !wdQ;
      rstReq  <= expire && wdQ;
      wdFired <= wdFired || (expire && wdQ);
      refused <= refuseWr;
    end
  end

  assign running  = enQ;
  assign wdLocked = wdQ && enQ;

  // R7
  sticky_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdFired |=> wdFired);

  // R7
  reset_from_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(wdLocked));

  // R10
  refuse_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    refused |-> (wdLocked && $past(wdLocked)));

  // R5
  one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expTick && !$past(contQ) && !$past(modeWr)) |-> !running);

  generate
    if (NO_WAY_OUT) begin : g_nowayout
      // R11
      lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(wdLocked) |-> wdLocked);
    end
  endgenerate
endmodule

// File: rtl/prescaled_watch_timer.sv
module prescaled_watch_timer
  import pwt_pkg::*;
#(
  parameter int         PRE_W      = 16,
  parameter int         CNT_W      = 16,
  parameter logic [7:0] KICK_VAL   = 8'hA5,
  parameter bit         NO_WAY_OUT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWr,
  input  logic        countWr,
  input  logic        kickWr,
  input  logic [31:0] wrData,
  input  logic [7:0]  kickByte,
  output logic        expTick,
  output logic        rstReq,
  output logic        wdFired,
  output logic        refused,
  output logic        running,
  output logic        wdLocked
);
  dp_strobe_t       strb;
  logic [PRE_W-1:0] preVal;
  logic [CNT_W-1:0] perVal;
  logic             expire;

  pwt_mode_ctrl #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .KICK_VAL(KICK_VAL), .NO_WAY_OUT(NO_WAY_OUT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .countWr(countWr),
    .kickWr(kickWr), .wrData(wrData), .kickByte(kickByte), .expire(expire),
    .strb(strb), .preVal(preVal), .perVal(perVal), .expTick(expTick),
    .rstReq(rstReq), .wdFired(wdFired), .refused(refused),
    .running(running), .wdLocked(wdLocked)
  );

  pwt_count_path #(
    .PRE_W(PRE_W), .CNT_W(CNT_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .preVal(preVal),
    .perVal(perVal), .expire(expire)
  );
endmodule

// File: tb/sim_prescaled_watch_timer.sv
module sim_prescaled_watch_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWr = 1'b0, countWr = 1'b0, kickWr = 1'b0;
  logic [31:0] wrData = '0;
  logic [7:0]  kickByte = '0;
  logic expTick, rstReq, wdFired, refused, running, wdLocked;

  int vecs = 0;
  int fails = 0;
  int cyc = 0;
  int    expKind[$];
  int    expAt[$];
  string expReq[$];

  localparam logic [31:0] M_EN = 32'h0000_1000;
  localparam logic [31:0] M_CO = 32'h0000_0400;
  localparam logic [31:0] M_WD = 32'h0000_8000;

  prescaled_watch_timer u0 (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .countWr(countWr),
    .kickWr(kickWr), .wrData(wrData), .kickByte(kickByte),
    .expTick(expTick), .rstReq(rstReq), .wdFired(wdFired),
    .refused(refused), .running(running), .wdLocked(wdLocked)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard driver side: kind 1 = timer expiry, 2 = reset request.
  task automatic pushExp(input int kind, input int at, input string req);
    expKind.push_back(kind);
    expAt.push_back(at);
    expReq.push_back(req);
  endtask

  // Monitor: pops one expected item for every observed pulse.
  always @(negedge clk) begin
    if (rstN && (expTick || rstReq)) begin
      int kind;
      kind = (expTick ? 1 : 0) + (rstReq ? 2 : 0);
      if (expKind.size() == 0) begin
        chk("R4", "unexpected pulse kind", kind, 0);
      end else begin
        int k; int a; string r;
        k = expKind.pop_front();
        a = expAt.pop_front();
        r = expReq.pop_front();
        chk(r, "pulse kind", kind, k);
        chk(r, "pulse cycle", cyc, a);
      end
    end
  end

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic writeMode(input logic [31:0] d, output int capAt);
    @(negedge clk); modeWr = 1'b1; wrData = d;
    @(negedge clk); modeWr = 1'b0; capAt = cyc;
  endtask

  task automatic writeCount(input logic [15:0] p, input logic [15:0] c);
    @(negedge clk); countWr = 1'b1; wrData = {p, c};
    @(negedge clk); countWr = 1'b0;
  endtask

  task automatic kick(input logic [7:0] b, output int capAt);
    @(negedge clk); kickWr = 1'b1; kickByte = b;
    @(negedge clk); kickWr = 1'b0; capAt = cyc;
  endtask

  task automatic drained(input string req);
    chk(req, "pending expected pulses", expKind.size(), 0);
  endtask

  task automatic applyReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    int t, s, k, r, u, kx;
    applyReset();
    // R1 reset state
    chk("R1", "expTick", expTick, 0);
    chk("R1", "rstReq", rstReq, 0);
    chk("R1", "wdFired", wdFired, 0);
    chk("R1", "refused", refused, 0);
    chk("R1", "running", running, 0);
    chk("R1", "wdLocked", wdLocked, 0);
    rstN = 1'b1;

    // R2 / R5: one-shot, P=3, C=4
    writeCount(16'd3, 16'd4);
    writeMode(M_EN, t);
    pushExp(1, t + 12, "R2");
    waitUntil(t + 30);
    chk("R5", "running after one-shot", running, 0);
    drained("R5");

    // R2: P=1, C=1 gives one cycle
    writeCount(16'd1, 16'd1);
    writeMode(M_EN, t);
    pushExp(1, t + 1, "R2");
    waitUntil(t + 6);
    drained("R2");

    // R6 continuous, then R4 stop
    writeCount(16'd2, 16'd3);
    writeMode(M_EN | M_CO, t);
    pushExp(1, t + 6, "R6");
    pushExp(1, t + 12, "R6");
    pushExp(1, t + 18, "R6");
    waitUntil(t + 20);
    writeMode(32'h0, s);
    chk("R4", "running after stop", running, 0);
    waitUntil(s + 30);
    drained("R4");

    // R7..R11 watchdog path, P=4, C=10 (period 40)
    writeCount(16'd4, 16'd10);
    writeMode(M_WD | M_EN | M_CO, t);
    chk("R7", "locked after watchdog start", wdLocked, 1);
    waitUntil(t + 20);
    kick(8'hA5, k);
    pushExp(2, k + 40, "R8");
    pushExp(2, k + 80, "R7");
    waitUntil(k + 10);
    kick(8'h5A, kx);                  // R9: no effect on timing
    waitUntil(k + 15);
    writeMode(M_EN, r);               // plain timer request while locked
    chk("R10", "refused pulse", refused, 1);
    chk("R10", "lock kept", wdLocked, 1);
    @(negedge clk);
    chk("R10", "refused one cycle", refused, 0);
    waitUntil(k + 85);
    chk("R7", "wdFired", wdFired, 1);
    chk("R9", "events after bad key", expKind.size(), 0);
    writeMode(32'h0, u);
    chk("R11", "unlocked", wdLocked, 0);
    chk("R11", "stopped", running, 0);
    chk("R11", "unlock not refused", refused, 0);
    waitUntil(u + 60);
    drained("R11");
    chk("R7", "wdFired sticky", wdFired, 1);

    applyReset();
    chk("R7", "wdFired cleared by reset", wdFired, 0);
    rstN = 1'b1;

    // R3: prescale 0 -> 65536
    writeCount(16'd0, 16'd1);
    writeMode(M_EN, t);
    pushExp(1, t + 65536, "R3");
    waitUntil(t + 65540);
    drained("R3");

    // R3: period 0 -> 65536 ticks
    writeCount(16'd1, 16'd0);
    writeMode(M_EN, t);
    pushExp(1, t + 65536, "R3");
    waitUntil(t + 65540);
    drained("R3");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule